// File: doc/BRIEF.md
# Paced Scan-List Conversion Sequencer

This block drives an analog-to-digital converter through a programmable list of channel entries. Software fills the list through a byte-wide write port, loads a 24-bit pacer period, selects one of three internal pacer clocks or an external tick, and arms the sequencer. For each entry the block presents channel, gain and input mode, pulses a one-cycle convert strobe, and waits for the converter's done pulse. It then forwards the 16-bit result as a one-cycle sample.

Each entry carries a start flag. A flagged entry holds until the next pacer tick. An unflagged entry converts as soon as the previous result arrives. Flagging every entry paces each conversion. Flagging only the first entry paces whole scans, and the conversions inside a scan run back to back. When the last entry's result arrives, an end-of-scan flag latches, and it can raise an interrupt. In one-shot mode the block then returns to idle. In continuous mode it wraps to the first entry and runs until it is stopped.

Top module: `scan_pacer_seq`

## Requirements
- R1: After reset, statusOut reads 0x80 (idle), irq is 0, convStart is 0 and sampleValid is 0.
- R2: The pacer period is assembled from byte writes to addresses 2 (bits 7:0), 3 (bits 15:8) and 4 (bits 23:16). Pacer ticks come every N pacer-clock periods and the count reloads on each tick. A programmed N of 0 means 2^24 periods, so no tick appears within a short window.
- R3: Control register (address 1) bits 7:6 select the pacer clock. 11 gives CLK_HZ/100 kHz cycles per period, 10 gives CLK_HZ/1 MHz, 01 gives CLK_HZ/5 MHz, and 00 counts one period per cycle in which extTick is high.
- R4: An entry is appended by two byte writes to address 0, low byte first. Bit 14 is differential, bits 13:12 are gain, bits 11:8 are channel and bit 7 is the start flag. Diff, gain and channel appear on convDiff, convGain and convChan while convStart is high.
- R5: An entry with its start flag set waits for a pacer tick, and convStart rises the cycle after the tick. An entry without the flag raises convStart two cycles after the cycle in which the previous convDone was high.
- R6: A write to command address 5 acts on three bits. Bit 7 arms; it is ignored when the queue is empty or a run is already active. Bit 4 stops, and the block is idle on the next cycle. Bit 5 empties the queue and also stops.
- R7: With control bit 2 clear (one-shot), the block runs the queue once and goes idle after the last result. With it set (continuous), the block wraps to entry 0 until stopped.
- R8: Status bit 4 sets when the last entry's result arrives and clears on a statRd pulse. irq equals that bit ANDed with control bit 4. Status bit 7 means idle and bit 6 means running.
- R9: The queue holds DEPTH entries. Complete entries written beyond DEPTH are discarded.
- R10: convData is captured when convDone is high during a conversion. sampleOut then holds it and sampleValid pulses for one cycle on the next cycle.
- R11: convStart lasts one cycle, and no new convStart occurs until convDone returns for the current conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write byte |
| statRd | input | 1 | Status read pulse, clears end-of-scan |
| extTick | input | 1 | External pacer clock enable |
| statusOut | output | 8 | Status: bit 7 idle, bit 6 running, bit 4 end-of-scan |
| irq | output | 1 | End-of-scan interrupt |
| convStart | output | 1 | Convert strobe |
| convChan | output | 4 | Channel of current entry |
| convGain | output | 2 | Gain code of current entry |
| convDiff | output | 1 | Differential select of current entry |
| convDone | input | 1 | Converter done pulse |
| convData | input | 16 | Converter result |
| sampleValid | output | 1 | Result valid pulse |
| sampleOut | output | 16 | Captured result |

## Verification
The bench runs a cycle-accurate behavioural model beside the design and compares strobes, entry fields, samples and status on every clock. Stimulus covers four cases. A queue with every entry flagged, in one-shot mode, separates per-conversion pacing from bursts. A queue with only the first entry flagged, in continuous mode, shows the four-cycle burst spacing and the wrap to entry 0. Each clock source is tried in turn so the gaps between strobes tell the divisors apart. The remaining runs cover overfilling the queue, arming an empty queue, stopping mid-run and a zero pacer count, which exercise the limits.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PACE, S_FIRE, S_BUSY} seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pacerRestart;
    logic pacerRun;
    logic idxClear;
    logic idxInc;
    logic capture;
  } seqStrobe_t;

  // Stored queue entry: only the decoded fields
  typedef struct packed {
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic       start;
  } qEntry_t;

  localparam logic [2:0] ADDR_QUEUE   = 3'd0;
  localparam logic [2:0] ADDR_CTRL    = 3'd1;
  localparam logic [2:0] ADDR_PACE_LO = 3'd2;
  localparam logic [2:0] ADDR_PACE_MD = 3'd3;
  localparam logic [2:0] ADDR_PACE_HI = 3'd4;
  localparam logic [2:0] ADDR_CMD     = 3'd5;

  localparam int CMD_ARM  = 7;
  localparam int CMD_QRST = 5;
  localparam int CMD_STOP = 4;

  localparam int CTL_CONT  = 2;
  localparam int CTL_EOSIE = 4;

endpackage

// File: rtl/scanseq_dp.sv
module scanseq_dp
  import scanseq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CLK_HZ = 20_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic        extTick,
  input  logic [15:0] convData,
  input  seqStrobe_t  strb,
  output logic        armCmd,
  output logic        stopCmd,
  output logic        qrstCmd,
  output logic        queueEmpty,
  output logic        curStart,
  output logic        lastEntry,
  output logic        pacerTick,
  output logic        contMode,
  output logic        eosIntEn,
  output logic [3:0]  entryChan,
  output logic [1:0]  entryGain,
  output logic        entryDiff,
  output logic        sampleValid,
  output logic [15:0] sampleOut
);

  localparam int CW       = $clog2(DEPTH + 1);
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PACER_W  = 24;
  localparam int DIV_FAST = (CLK_HZ / 5_000_000 > 0) ? CLK_HZ / 5_000_000 : 1;
  localparam int DIV_MID  = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int DIV_SLOW = (CLK_HZ / 100_000 > 0) ? CLK_HZ / 100_000 : 1;
  localparam int PW       = $clog2(DIV_SLOW + 1);

  qEntry_t               queue [DEPTH];
  logic [CW-1:0]         queueCnt;
  logic [IW-1:0]         idx;
  logic                  bytePhase;
  logic                  loStart;
  logic [1:0]            clkSel;
  logic [7:0]            paceLo, paceMd, paceHi;
  logic [PACER_W-1:0]    progVal, pacerCnt;
  logic [PW-1:0]         presc, prescTop;
  logic                  preTick;
  qEntry_t               curEntry;

  wire cmdWr   = regWr && (regAddr == ADDR_CMD);
  wire queueWr = regWr && (regAddr == ADDR_QUEUE);
  assign armCmd  = cmdWr && regWrData[CMD_ARM];
  assign stopCmd = cmdWr && regWrData[CMD_STOP];
  assign qrstCmd = cmdWr && regWrData[CMD_QRST];

  // Register file and queue fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      queueCnt  <= '0;
      bytePhase <= 1'b0;
      loStart   <= 1'b0;
      clkSel    <= 2'b00;
      contMode  <= 1'b0;
      eosIntEn  <= 1'b0;
      paceLo    <= '0;
      paceMd    <= '0;
      paceHi    <= '0;
    end else if (qrstCmd) begin
      queueCnt  <= '0;
      bytePhase <= 1'b0;
    end else if (regWr) begin
      unique case (regAddr)
        ADDR_QUEUE: begin
          bytePhase <= !bytePhase;
          if (!bytePhase) loStart <= regWrData[7];
          else if (queueCnt < CW'(DEPTH)) queueCnt <= queueCnt + CW'(1);
        end
        ADDR_CTRL: begin
          clkSel   <= regWrData[7:6];
          contMode <= regWrData[CTL_CONT];
          eosIntEn <= regWrData[CTL_EOSIE];
        end
        ADDR_PACE_LO: paceLo <= regWrData;
        ADDR_PACE_MD: paceMd <= regWrData;
        ADDR_PACE_HI: paceHi <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (queueWr && bytePhase && (queueCnt < CW'(DEPTH)) && !qrstCmd)
      queue[queueCnt[IW-1:0]] <= '{diff: regWrData[6], gain: regWrData[5:4],
                                   chan: regWrData[3:0], start: loStart};
  end

  // Pacer: prescaler followed by reloading down-counter
  assign progVal = {paceHi, paceMd, paceLo};

  always_comb begin
    unique case (clkSel)
      2'b11:   prescTop = PW'(DIV_SLOW - 1);
      2'b10:   prescTop = PW'(DIV_MID - 1);
      2'b01:   prescTop = PW'(DIV_FAST - 1);
      default: prescTop = '0;
    endcase
  end

  assign preTick   = (clkSel == 2'b00) ? extTick : (presc == prescTop);
  assign pacerTick = strb.pacerRun && preTick && (pacerCnt == PACER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc    <= '0;
      pacerCnt <= '0;
    end else if (strb.pacerRestart) begin
      presc    <= '0;
      pacerCnt <= progVal;
    end else if (strb.pacerRun) begin
      if (clkSel != 2'b00) presc <= (presc == prescTop) ? '0 : presc + PW'(1);
      if (preTick) pacerCnt <= (pacerCnt == PACER_W'(1)) ? progVal : pacerCnt - PACER_W'(1);
    end
  end

  // Entry index and result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx         <= '0;
      sampleValid <= 1'b0;
      sampleOut   <= '0;
    end else begin
      if (strb.idxClear)    idx <= '0;
      else if (strb.idxInc) idx <= idx + IW'(1);
      sampleValid <= strb.capture;
      if (strb.capture) sampleOut <= convData;
    end
  end

  assign curEntry   = queue[idx];
  assign curStart   = curEntry.start;
  assign entryChan  = curEntry.chan;
  assign entryGain  = curEntry.gain;
  assign entryDiff  = curEntry.diff;
  assign queueEmpty = (queueCnt == '0);
  assign lastEntry  = ((CW'(idx) + CW'(1)) == queueCnt);

  p_pacer_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pacerTick && !strb.pacerRestart) |=> (pacerCnt == $past(progVal)));

  p_queue_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    queueCnt <= CW'(DEPTH));

  p_idx_in_queue_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.pacerRun |-> (CW'(idx) < queueCnt));

  p_sample_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (sampleValid && sampleOut == $past(convData)));

endmodule

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
  import scanseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armCmd,
  input  logic       stopCmd,
  input  logic       qrstCmd,
  input  logic       queueEmpty,
  input  logic       curStart,
  input  logic       lastEntry,
  input  logic       pacerTick,
  input  logic       contMode,
  input  logic       convDone,
  input  logic       statRd,
  output seqStrobe_t strb,
  output logic       convStart,
  output logic       idle,
  output logic       eosFlag
);

  seqState_t state, nextState;
  logic      eosSet;

  always_comb begin
    nextState     = state;
    strb          = '0;
    strb.pacerRun = (state != S_IDLE);
    eosSet        = 1'b0;
    if (stopCmd || qrstCmd) begin
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (armCmd && !queueEmpty) begin
          nextState         = S_PACE;
          strb.pacerRestart = 1'b1;
          strb.idxClear     = 1'b1;
        end
        S_PACE: if (!curStart || pacerTick) nextState = S_FIRE;
        S_FIRE: nextState = S_BUSY;
        S_BUSY: if (convDone) begin
          strb.capture = 1'b1;
          if (lastEntry) begin
            eosSet = 1'b1;
            if (contMode) begin
              strb.idxClear = 1'b1;
              nextState     = S_PACE;
            end else begin
              nextState = S_IDLE;
            end
          end else begin
            strb.idxInc = 1'b1;
            nextState   = S_PACE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      eosFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (eosSet)      eosFlag <= 1'b1;
      else if (statRd) eosFlag <= 1'b0;
    end
  end

  assign convStart = (state == S_FIRE);
  assign idle      = (state == S_IDLE);

  p_fire_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_wait_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PACE && curStart && !pacerTick && !stopCmd && !qrstCmd) |=> !convStart);

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd || qrstCmd) |=> idle);

  p_empty_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idle && armCmd && queueEmpty) |=> idle);

  p_oneshot_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && convDone && lastEntry && !contMode && !stopCmd && !qrstCmd)
      |=> (idle && eosFlag));

endmodule

// File: rtl/scan_pacer_seq.sv
module scan_pacer_seq
  import scanseq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CLK_HZ = 20_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic        statRd,
  input  logic        extTick,
  output logic [7:0]  statusOut,
  output logic        irq,
  output logic        convStart,
  output logic [3:0]  convChan,
  output logic [1:0]  convGain,
  output logic        convDiff,
  input  logic        convDone,
  input  logic [15:0] convData,
  output logic        sampleValid,
  output logic [15:0] sampleOut
);

  seqStrobe_t strb;
  logic armCmd, stopCmd, qrstCmd, queueEmpty, curStart, lastEntry;
  logic pacerTick, contMode, eosIntEn, idle, eosFlag;

  scanseq_dp #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .extTick(extTick), .convData(convData), .strb(strb),
    .armCmd(armCmd), .stopCmd(stopCmd), .qrstCmd(qrstCmd), .queueEmpty(queueEmpty),
    .curStart(curStart), .lastEntry(lastEntry), .pacerTick(pacerTick),
    .contMode(contMode), .eosIntEn(eosIntEn),
    .entryChan(convChan), .entryGain(convGain), .entryDiff(convDiff),
    .sampleValid(sampleValid), .sampleOut(sampleOut)
  );

  scanseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .armCmd(armCmd), .stopCmd(stopCmd), .qrstCmd(qrstCmd),
    .queueEmpty(queueEmpty), .curStart(curStart), .lastEntry(lastEntry),
    .pacerTick(pacerTick), .contMode(contMode), .convDone(convDone), .statRd(statRd),
    .strb(strb), .convStart(convStart), .idle(idle), .eosFlag(eosFlag)
  );

  assign statusOut = {idle, !idle, 1'b0, eosFlag, 4'b0000};
  assign irq       = eosFlag && eosIntEn;

endmodule

// File: tb/scan_pacer_seq_test.sv
module scan_pacer_seq_test;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        statRd = 1'b0;
  logic        extTick = 1'b0;
  logic        convDone = 1'b0;
  logic [15:0] convData = '0;
  logic [7:0]  statusOut;
  logic        irq, convStart, convDiff, sampleValid;
  logic [3:0]  convChan;
  logic [1:0]  convGain;
  logic [15:0] sampleOut;

  scan_pacer_seq #(.DEPTH(DEPTH), .CLK_HZ(100_000_000)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .statRd(statRd), .extTick(extTick), .statusOut(statusOut), .irq(irq),
    .convStart(convStart), .convChan(convChan), .convGain(convGain), .convDiff(convDiff),
    .convDone(convDone), .convData(convData), .sampleValid(sampleValid), .sampleOut(sampleOut)
  );

  always #5 clk = !clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int extPer = 0;
  int convWait = -1;
  int dataSeed = 16'h3a00;
  int startCount = 0;
  int validCount = 0;
  int startCyc [64];
  int startInfo [64];
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (updated on each rising edge) ----------------
  int mState, mIdx, mCnt, mPhase, mLoStart, mCtrl, mProg, mPresc, mPcnt, mEos, mSampV, mSampOut;
  int mQ [DEPTH];

  function automatic int divOf(input int sel);
    case (sel)
      3: return 1000;
      2: return 100;
      1: return 20;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mCnt = 0; mPhase = 0; mLoStart = 0; mCtrl = 0; mProg = 0;
      mPresc = 0; mPcnt = 0; mEos = 0; mSampV = 0; mSampOut = 0;
    end else begin
      bit armC, stopC, qrC, preT, pTick, last, curS, restart, clr, inc, cap, eosSet;
      int nState, sel, dv;
      armC  = regWr && regAddr == 5 && regWrData[7];
      stopC = regWr && regAddr == 5 && regWrData[4];
      qrC   = regWr && regAddr == 5 && regWrData[5];
      sel   = (mCtrl >> 6) & 3;
      dv    = divOf(sel);
      preT  = (sel == 0) ? extTick : (mPresc == dv - 1);
      pTick = (mState != 0) && preT && (mPcnt == 1);
      last  = (mIdx + 1 == mCnt);
      curS  = (mQ[mIdx] >> 7) & 1;
      nState = mState; restart = 0; clr = 0; inc = 0; cap = 0; eosSet = 0;
      if (stopC || qrC) nState = 0;
      else case (mState)
        0: if (armC && mCnt > 0) begin nState = 1; restart = 1; clr = 1; end
        1: if (!curS || pTick) nState = 2;
        2: nState = 3;
        3: if (convDone) begin
             cap = 1;
             if (last) begin
               eosSet = 1;
               if ((mCtrl >> 2) & 1) begin clr = 1; nState = 1; end else nState = 0;
             end else begin inc = 1; nState = 1; end
           end
        default: nState = 0;
      endcase
      if (restart) begin mPresc = 0; mPcnt = mProg; end
      else if (mState != 0) begin
        if (sel != 0) mPresc = (mPresc == dv - 1) ? 0 : mPresc + 1;
        if (preT) mPcnt = (mPcnt == 1) ? mProg : ((mPcnt - 1) & 24'hffffff);
      end
      mSampV = cap;
      if (cap) mSampOut = convData;
      if (clr) mIdx = 0; else if (inc) mIdx = mIdx + 1;
      if (eosSet) mEos = 1; else if (statRd) mEos = 0;
      if (qrC) begin mCnt = 0; mPhase = 0; end
      else if (regWr) begin
        case (regAddr)
          0: begin
               if (mPhase == 0) mLoStart = regWrData[7];
               else if (mCnt < DEPTH) begin
                 mQ[mCnt] = (regWrData << 8) | (mLoStart << 7);
                 mCnt = mCnt + 1;
               end
               mPhase = 1 - mPhase;
             end
          1: mCtrl = regWrData;
          2: mProg = (mProg & 24'hffff00) | regWrData;
          3: mProg = (mProg & 24'hff00ff) | (regWrData << 8);
          4: mProg = (mProg & 24'h00ffff) | (regWrData << 16);
          default: ;
        endcase
      end
      mState = nState;
    end
  end

  // ---------------- per-cycle comparison, converter and ext tick (falling edge) ----------------
  always @(negedge clk) begin
    cyc++;
    if (rstN && !finished) begin
      int expStat, mEnt;
      expStat = (mState == 0 ? 8'h80 : 8'h40) | (mEos ? 8'h10 : 0);
      mEnt = mQ[mIdx];
      check(statusOut == expStat[7:0], "R6/R7/R8", "status", statusOut, expStat);
      check(irq == (mEos && ((mCtrl >> 4) & 1)), "R8", "irq", irq, mEos && ((mCtrl >> 4) & 1));
      check(convStart == (mState == 2), "R5/R11", "convStart", convStart, mState == 2);
      if (convStart && mState == 2)
        check({convDiff, convGain, convChan} == mEnt[14:8], "R4", "entry fields",
              {convDiff, convGain, convChan}, mEnt[14:8]);
      check(sampleValid == mSampV, "R10", "sampleValid", sampleValid, mSampV);
      if (sampleValid) check(sampleOut == mSampOut[15:0], "R10", "sampleOut", sampleOut, mSampOut);
    end
    if (convStart) begin
      if (startCount < 64) begin
        startCyc[startCount]  = cyc;
        startInfo[startCount] = {convDiff, convGain, convChan};
      end
      startCount++;
    end
    if (sampleValid) validCount++;
    convDone = 1'b0;
    if (convWait > 0) convWait--;
    if (convWait == 0) begin
      convDone = 1'b1;
      convData = dataSeed[15:0];
      dataSeed = dataSeed + 16'h0111;
      convWait = -1;
    end
    if (convStart) convWait = 2;
    extTick = (extPer > 0) && (cyc % extPer == 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic wrEntry(input logic [15:0] e);
    wrReg(3'd0, e[7:0]);
    wrReg(3'd0, e[15:8]);
  endtask

  task automatic wrPace(input int n);
    wrReg(3'd2, n[7:0]);
    wrReg(3'd3, n[15:8]);
    wrReg(3'd4, n[23:16]);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStatRd();
    @(negedge clk); statRd = 1'b1;
    @(negedge clk); statRd = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    idleCycles(3);
    // R1: reset state
    check(statusOut == 8'h80, "R1", "reset status", statusOut, 8'h80);
    check(irq == 1'b0 && convStart == 1'b0 && sampleValid == 1'b0, "R1", "reset outputs",
          {irq, convStart, sampleValid}, 0);
    @(negedge clk); rstN = 1'b1;
    idleCycles(2);

    // Per-conversion pacing, 5 MHz (20 cycles), count 3 -> 60 cycles, one-shot, irq on
    wrPace(3);
    wrReg(3'd1, 8'h50);
    wrEntry(16'h6180);
    wrEntry(16'h0580);
    wrEntry(16'h3780);
    startCount = 0; validCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(300);
    check(startCount == 3, "R7", "one-shot conversions", startCount, 3);
    check(startCyc[1] - startCyc[0] == 60, "R2", "pacer gap", startCyc[1] - startCyc[0], 60);
    check(startCyc[2] - startCyc[1] == 60, "R3", "5 MHz divisor gap", startCyc[2] - startCyc[1], 60);
    check(startInfo[0] == 7'b1_10_0001, "R4", "entry 0 fields", startInfo[0], 7'b1_10_0001);
    check(startInfo[2] == 7'b0_11_0111, "R4", "entry 2 fields", startInfo[2], 7'b0_11_0111);
    check(validCount == 3, "R10", "sample pulses", validCount, 3);
    check(statusOut == 8'h90 && irq, "R8", "eos latched and irq", {statusOut, irq}, {8'h90, 1'b1});
    pulseStatRd();
    @(negedge clk);
    check(statusOut == 8'h80 && !irq, "R8", "eos cleared", {statusOut, irq}, {8'h80, 1'b0});

    // Per-scan pacing with bursts, continuous, irq disabled
    wrReg(3'd5, 8'h20);
    wrPace(10);
    wrReg(3'd1, 8'h44);
    wrEntry(16'h0280);
    wrEntry(16'h0300);
    wrEntry(16'h0400);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(500);
    check(startCount >= 6, "R7", "continuous wrap", startCount, 6);
    check(startCyc[1] - startCyc[0] == 4, "R5", "burst gap", startCyc[1] - startCyc[0], 4);
    check(startCyc[3] - startCyc[0] == 200, "R5", "scan period", startCyc[3] - startCyc[0], 200);
    check(startInfo[3] == 7'b0_00_0010, "R7", "wrap to entry 0", startInfo[3], 7'b0_00_0010);
    check(statusOut[4] && !irq, "R8", "eos without irq enable", {statusOut[4], irq}, 2'b10);
    wrReg(3'd5, 8'h10);
    check(statusOut[7:6] == 2'b10, "R6", "stop to idle", statusOut[7:6], 2'b10);
    pulseStatRd();

    // Clock selects with a single flagged entry
    wrReg(3'd5, 8'h20);
    wrEntry(16'h0180);
    wrPace(2);
    wrReg(3'd1, 8'h84);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(700);
    wrReg(3'd5, 8'h10);
    check(startCyc[2] - startCyc[1] == 200, "R3", "1 MHz gap", startCyc[2] - startCyc[1], 200);
    wrPace(1);
    wrReg(3'd1, 8'hC4);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(3200);
    wrReg(3'd5, 8'h10);
    check(startCyc[2] - startCyc[1] == 1000, "R3", "100 kHz gap", startCyc[2] - startCyc[1], 1000);
    extPer = 3;
    wrPace(2);
    wrReg(3'd1, 8'h04);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(60);
    wrReg(3'd5, 8'h10);
    check(startCyc[2] - startCyc[1] == 6, "R3", "external tick gap", startCyc[2] - startCyc[1], 6);

    // Zero count: maximum period
    extPer = 1;
    wrPace(0);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(3000);
    check(startCount == 0, "R2", "zero count no tick", startCount, 0);
    wrReg(3'd5, 8'h10);
    extPer = 0;

    // Depth overflow, unflagged entries, one-shot
    wrReg(3'd5, 8'h20);
    for (int i = 0; i < 10; i++) wrEntry(16'(i << 8));
    wrReg(3'd1, 8'h40);
    startCount = 0;
    wrReg(3'd5, 8'h80);
    idleCycles(100);
    check(startCount == DEPTH, "R9", "entries beyond depth dropped", startCount, DEPTH);
    check(startInfo[DEPTH-1] == 7'(DEPTH - 1), "R9", "last kept entry", startInfo[DEPTH-1], DEPTH - 1);

    // Stop in mid conversion, then arm on an empty queue
    wrReg(3'd5, 8'h80);
    idleCycles(6);
    wrReg(3'd5, 8'h10);
    check(statusOut[7] == 1'b1, "R6", "stop mid-run", statusOut, 8'h80);
    wrReg(3'd5, 8'h20);
    wrReg(3'd5, 8'h80);
    idleCycles(3);
    check(statusOut[7:6] == 2'b10, "R6", "arm on empty queue ignored", statusOut[7:6], 2'b10);

    idleCycles(5);
    summary();
  end

endmodule